// File: doc/BRIEF.md
# Strap-Addressed I2C Configuration Register Target

This block is an I2C target that gives a bus master access to a bank of 8-bit configuration registers. The registers themselves sit outside the block, behind a simple write strobe and a combinational read port. The block oversamples SCL and SDA with the system clock and detects start, repeated start and stop conditions. It accepts a 7-bit device address made of a fixed high nibble and three strap pins. It drives SDA only through an open-drain output enable.

A write transfer carries the device address with the direction bit clear, then a register index, then one data byte. A read uses the combined format. The master first sends a write-direction address and the index. It then issues a repeated start and the same address with the direction bit set, and the target returns the indexed register. The index is held in a pointer that survives repeated starts and stop conditions. A read-direction address that arrives with no index byte before it therefore returns the register chosen last. After a read byte the master may stop, re-read through another read-direction address, or open a new write.

Top module: `i2c_cfg_target`

## Requirements
- R1: The target acknowledges only the 7-bit address {4'b1001, strap_i[2], strap_i[1], strap_i[0]}. On any other address it leaves SDA released for the acknowledge bit and for every later bit up to the next start or stop, and it writes no register.
- R2: Every byte is shifted MSB first, both into the target and out of it.
- R3: SDA falling while SCL is high is a start or repeated start, and it restarts address reception. SDA rising while SCL is high is a stop, and it releases SDA and returns the target to idle. A transfer cut short by a stop does not block the next transfer.
- R4: The first byte after a matching write-direction address (R/W = 0) is loaded into the register pointer and acknowledged. A transfer that ends after that byte writes no register.
- R5: The second byte after a matching write-direction address is written once, as a single-cycle rf_we pulse with rf_waddr equal to the pointer and rf_wdata equal to the byte, and it is acknowledged. Any further bytes in that transfer are not acknowledged and are not written.
- R6: After a matching read-direction address (R/W = 1) is acknowledged, the target drives the 8 bits of rf_rdata at rf_raddr = pointer, then releases SDA for the ninth clock.
- R7: The pointer is kept across repeated starts and stop conditions. A read-direction address sent without an index byte returns the register the pointer already selects.
- R8: After a read byte, a repeated start into a write-direction address begins a normal write transfer.
- R9: SCL and SDA pass through a two-flop synchronizer, and sda_oe is asserted only while the synchronized SCL is low.
- R10: After reset, sda_oe and rf_we are 0 and the pointer (rf_raddr) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| strap_i | input | 3 | Low three device-address bits, strap_i[0] is the LSB |
| rf_we | output | 1 | Single-cycle register write strobe |
| rf_waddr | output | 8 | Register index for the write |
| rf_wdata | output | 8 | Data byte for the write |
| rf_raddr | output | 8 | Register index being read (the pointer) |
| rf_rdata | input | 8 | Contents of the register at rf_raddr |

## Verification
The hardest case to reach is a read-direction address that follows a repeated start directly, with no index byte in between, after the indexed register has changed. To get there, the bench first sets the pointer and reads once. It then rewrites that register through its own register model and issues a second repeated start straight into the read address. Only a target that kept its pointer returns the new value. A later transfer that starts with a read address after a stop confirms that the pointer also survives a stop condition.

// File: rtl/i2c_cfg_pkg.sv
// Package: shared types and constants for the I2C configuration target.
// Assumes 7-bit device addressing and 8-bit register index and data.
package i2c_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam int DEV_W  = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_SKIP
    } tgt_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the clock domain through a flop chain of
// SYNC_STAGES stages and derives bus events from the synchronized lines.
// Assumes SYNC_STAGES >= 2 and that both lines idle high.
module i2c_line_sync
    import i2c_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt,
    output logic     scl_lvl
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;
    logic                   sda_s;

    // Synchronizer chains, reset to the idle-high bus level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Bus conditions: SDA moving while SCL stays high, and SCL edges.
    always_comb begin
        evt.start    = scl_s && scl_q && sda_q && !sda_s;
        evt.stop     = scl_s && scl_q && !sda_q && sda_s;
        evt.scl_rise = scl_s && !scl_q;
        evt.scl_fall = !scl_s && scl_q;
        evt.sda      = sda_s;
    end

    assign scl_lvl = scl_s;

endmodule

// File: rtl/i2c_target_fsm.sv
// Module: i2c_target_fsm
// Protocol engine. It matches the strapped address, loads the register
// pointer, issues the register write strobe and serializes read data.
// Samples SDA on synchronized SCL rises and changes its drive only on
// synchronized SCL falls. No stretching and no auto-increment.
module i2c_target_fsm
    import i2c_cfg_pkg::*;
#(
    parameter int                       STRAP_W = 3,
    parameter logic [DEV_W-STRAP_W-1:0] ADDR_HI = 4'b1001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic              scl_lvl,
    input  logic [STRAP_W-1:0] strap_i,
    output logic              sda_oe,
    output logic              rf_we,
    output logic [BYTE_W-1:0] rf_wdata,
    output logic [BYTE_W-1:0] ptr,
    input  logic [BYTE_W-1:0] rf_rdata
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

    tgt_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              matched;
    logic              rw;
    logic              ack_drv;
    logic [DEV_W-1:0]  dev_addr;
    logic [BYTE_W-1:0] rx_byte;

    assign dev_addr = {ADDR_HI, strap_i};
    assign rx_byte  = {shreg[BYTE_W-2:0], evt.sda};

    // Main sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            matched  <= 1'b0;
            rw       <= 1'b0;
            ack_drv  <= 1'b0;
            sda_oe   <= 1'b0;
            rf_we    <= 1'b0;
            rf_wdata <= '0;
            ptr      <= '0;
        end else begin
            rf_we <= 1'b0;
            if (evt.stop) begin
                state   <= ST_IDLE;
                sda_oe  <= 1'b0;
                ack_drv <= 1'b0;
            end else if (evt.start) begin
                state   <= ST_ADDR;
                cnt     <= '0;
                sda_oe  <= 1'b0;
                ack_drv <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (evt.scl_rise) begin
                            shreg <= rx_byte;
                            cnt   <= cnt + 1'b1;
                            if (cnt == LAST_BIT) begin
                                matched <= (shreg[DEV_W-1:0] == dev_addr);
                                rw      <= evt.sda;
                                cnt     <= '0;
                                state   <= ST_ADDR_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            if (!ack_drv) begin
                                if (matched) begin
                                    sda_oe  <= 1'b1;
                                    ack_drv <= 1'b1;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else begin
                                ack_drv <= 1'b0;
                                cnt     <= '0;
                                if (rw) begin
                                    shreg  <= rf_rdata;
                                    sda_oe <= !rf_rdata[BYTE_W-1];
                                    state  <= ST_RDATA;
                                end else begin
                                    sda_oe <= 1'b0;
                                    state  <= ST_INDEX;
                                end
                            end
                        end
                    end
                    ST_INDEX: begin
                        if (evt.scl_rise) begin
                            shreg <= rx_byte;
                            cnt   <= cnt + 1'b1;
                            if (cnt == LAST_BIT) begin
                                ptr   <= rx_byte;
                                cnt   <= '0;
                                state <= ST_INDEX_ACK;
                            end
                        end
                    end
                    ST_INDEX_ACK, ST_WDATA_ACK: begin
                        if (evt.scl_fall) begin
                            if (!ack_drv) begin
                                sda_oe  <= 1'b1;
                                ack_drv <= 1'b1;
                            end else begin
                                sda_oe  <= 1'b0;
                                ack_drv <= 1'b0;
                                cnt     <= '0;
                                state   <= (state == ST_INDEX_ACK) ? ST_WDATA : ST_SKIP;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (evt.scl_rise) begin
                            shreg <= rx_byte;
                            cnt   <= cnt + 1'b1;
                            if (cnt == LAST_BIT) begin
                                rf_we    <= 1'b1;
                                rf_wdata <= rx_byte;
                                cnt      <= '0;
                                state    <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (evt.scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (evt.scl_fall) begin
                            if (cnt == ALL_BITS) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RDATA_ACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= !shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_RDATA_ACK: begin
                        if (evt.scl_rise) begin
                            state <= ST_SKIP;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // R9: the pull-down starts only while the synchronized SCL is low.
    p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    // R5: the register write strobe lasts exactly one cycle.
    p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    // R3: a stop releases SDA and leaves the engine idle.
    p_stop_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> (!sda_oe && state == ST_IDLE));

    // R4 / R7: the pointer moves only when an index byte completes.
    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr) |-> $past(state) == ST_INDEX);

    // R1: after a mismatched address the target stays off the bus.
    p_skip_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_oe);

endmodule

// File: rtl/i2c_cfg_target.sv
// Module: i2c_cfg_target (top)
// I2C target for an external bank of 8-bit configuration registers.
// Joins the line synchronizer and the protocol engine. Expects an
// open-drain pad that pulls SDA low while sda_oe is 1.
module i2c_cfg_target
    import i2c_cfg_pkg::*;
#(
    parameter int                       SYNC_STAGES = 2,
    parameter int                       STRAP_W     = 3,
    parameter logic [DEV_W-STRAP_W-1:0] ADDR_HI     = 4'b1001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               rf_we,
    output logic [BYTE_W-1:0]  rf_waddr,
    output logic [BYTE_W-1:0]  rf_wdata,
    output logic [BYTE_W-1:0]  rf_raddr,
    input  logic [BYTE_W-1:0]  rf_rdata
);

    bus_evt_t          evt;
    logic              scl_lvl;
    logic [BYTE_W-1:0] ptr;

    i2c_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .evt    (evt),
        .scl_lvl(scl_lvl)
    );

    i2c_target_fsm #(
        .STRAP_W(STRAP_W),
        .ADDR_HI(ADDR_HI)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .scl_lvl (scl_lvl),
        .strap_i (strap_i),
        .sda_oe  (sda_oe),
        .rf_we   (rf_we),
        .rf_wdata(rf_wdata),
        .ptr     (ptr),
        .rf_rdata(rf_rdata)
    );

    // The same pointer selects both the write target and the read source.
    assign rf_waddr = ptr;
    assign rf_raddr = ptr;

endmodule

// File: tb/i2c_cfg_target_test.sv
// Directed bench: an I2C master model plus a register bank model.
module i2c_cfg_target_test;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 10;
    localparam logic [7:0] WR_ADDR = 8'h9A;  // {1001,101,0}
    localparam logic [7:0] RD_ADDR = 8'h9B;  // {1001,101,1}

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_line;
    logic       sda_oe;
    logic       rf_we;
    logic [7:0] rf_waddr, rf_wdata, rf_raddr, rf_rdata;
    logic [7:0] mem [0:255];
    logic       poke_en = 1'b0;
    logic [7:0] poke_addr = '0, poke_data = '0;
    int         we_count = 0;
    int         oe_viol = 0;
    logic       oe_prev = 1'b0;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = ~(m_low | sda_oe);
    assign rf_rdata = mem[rf_raddr];

    i2c_cfg_target uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(3'b101), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
    );

    // Register bank model: design writes and bench pokes.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
        end else if (poke_en) begin
            mem[poke_addr] <= poke_data;
        end else if (rf_we) begin
            mem[rf_waddr] <= rf_wdata;
            we_count <= we_count + 1;
        end
    end

    // R9 monitor: pull-down must not begin while the raw SCL is high.
    always @(negedge clk) begin
        if (rst_n && sda_oe && !oe_prev && scl_m) oe_viol <= oe_viol + 1;
        oe_prev <= sda_oe;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic qwait;
        repeat (QTR) @(negedge clk);
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        poke_addr = a; poke_data = d; poke_en = 1'b1;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic bus_start;
        m_low = 1'b0; qwait;
        scl_m = 1'b1; qwait;
        m_low = 1'b1; qwait;
        scl_m = 1'b0; qwait;
    endtask

    task automatic bus_stop;
        m_low = 1'b1; qwait;
        scl_m = 1'b1; qwait;
        m_low = 1'b0; qwait; qwait;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; qwait;
            scl_m = 1'b1; qwait; qwait;
            scl_m = 1'b0; qwait;
        end
        m_low = 1'b0; qwait;
        scl_m = 1'b1; qwait;
        ack = (sda_line == 1'b0);
        qwait;
        scl_m = 1'b0; qwait;
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] d);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            qwait;
            scl_m = 1'b1; qwait;
            d[i] = sda_line;
            qwait;
            scl_m = 1'b0;
        end
        qwait;
        m_low = ~nack; qwait;
        scl_m = 1'b1; qwait; qwait;
        scl_m = 1'b0; qwait;
        m_low = 1'b0;
    endtask

    task automatic t_reset;
        check("R10 sda_oe", sda_oe, 0);
        check("R10 rf_we", rf_we, 0);
        check("R10 pointer", rf_raddr, 0);
    endtask

    task automatic t_write;
        logic a; int w0 = we_count;
        bus_start;
        send_byte(WR_ADDR, a); check("R1 address ack", a, 1);
        send_byte(8'h05, a);   check("R4 index ack", a, 1);
        send_byte(8'hA7, a);   check("R5 data ack", a, 1);
        bus_stop;
        check("R5 register written", mem[8'h05], 8'hA7);
        check("R5 one write", we_count - w0, 1);
    endtask

    task automatic t_combined_read;
        logic a; logic [7:0] d;
        bus_start;
        send_byte(WR_ADDR, a); send_byte(8'h05, a);
        bus_start;
        send_byte(RD_ADDR, a); check("R6 read address ack", a, 1);
        read_byte(1'b0, d);    check("R6 R2 read data MSB first", d, 8'hA7);
        bus_stop;
        check("R3 released after stop", sda_oe, 0);
    endtask

    task automatic t_reread;
        logic a; logic [7:0] d;
        poke(8'h33, 8'h5C);
        bus_start;
        send_byte(WR_ADDR, a); send_byte(8'h33, a);
        bus_start;
        send_byte(RD_ADDR, a); read_byte(1'b0, d);
        check("R6 first read", d, 8'h5C);
        poke(8'h33, 8'hC1);
        bus_start;
        send_byte(RD_ADDR, a); check("R7 re-read ack", a, 1);
        read_byte(1'b1, d);    check("R7 re-read same index", d, 8'hC1);
        bus_stop;
        bus_start;
        send_byte(RD_ADDR, a); read_byte(1'b1, d);
        check("R7 pointer kept across stop", d, 8'hC1);
        bus_stop;
    endtask

    task automatic t_mismatch;
        logic a; logic [7:0] d; int w0 = we_count;
        bus_start;
        send_byte(8'h98, a);   check("R1 strap mismatch nack", a, 0);
        send_byte(8'h05, a);   check("R1 index ignored", a, 0);
        send_byte(8'h11, a);   check("R1 data ignored", a, 0);
        bus_stop;
        check("R1 no write on mismatch", we_count - w0, 0);
        check("R1 register unchanged", mem[8'h05], 8'hA7);
        bus_start;
        send_byte(8'h5B, a);   check("R1 high nibble mismatch nack", a, 0);
        read_byte(1'b1, d);    check("R1 no read drive", d, 8'hFF);
        bus_stop;
    endtask

    task automatic t_extra_byte;
        logic a; int w0 = we_count;
        bus_start;
        send_byte(WR_ADDR, a); send_byte(8'h40, a);
        send_byte(8'h11, a);   check("R5 data ack", a, 1);
        send_byte(8'h22, a);   check("R5 extra byte nack", a, 0);
        bus_stop;
        check("R5 data at index", mem[8'h40], 8'h11);
        check("R5 no auto-increment", mem[8'h41], 8'h1B);
        check("R5 single write", we_count - w0, 1);
    endtask

    task automatic t_index_only;
        logic a; logic [7:0] d; int w0 = we_count;
        bus_start;
        send_byte(WR_ADDR, a); send_byte(8'h60, a);
        check("R4 index ack", a, 1);
        bus_stop;
        check("R4 no write", we_count - w0, 0);
        check("R4 pointer loaded", rf_raddr, 8'h60);
        bus_start;
        send_byte(RD_ADDR, a); read_byte(1'b1, d);
        check("R4 read at new index", d, 8'h3A);
        bus_stop;
    endtask

    task automatic t_read_then_write;
        logic a; logic [7:0] d;
        bus_start;
        send_byte(WR_ADDR, a); send_byte(8'h05, a);
        bus_start;
        send_byte(RD_ADDR, a); read_byte(1'b1, d);
        check("R6 read before write", d, 8'hA7);
        bus_start;
        send_byte(WR_ADDR, a); check("R8 write address ack", a, 1);
        send_byte(8'h07, a);   check("R8 index ack", a, 1);
        send_byte(8'h3E, a);   check("R8 data ack", a, 1);
        bus_stop;
        check("R8 register written", mem[8'h07], 8'h3E);
    endtask

    task automatic t_abort;
        logic a;
        bus_start;
        send_byte(WR_ADDR, a);
        m_low = 1'b1; qwait;
        scl_m = 1'b1; qwait;
        m_low = 1'b0; qwait; qwait;
        check("R3 idle after mid-transfer stop", sda_oe, 0);
        bus_start;
        send_byte(WR_ADDR, a); check("R3 new transfer ack", a, 1);
        send_byte(8'h09, a); send_byte(8'h81, a);
        bus_stop;
        check("R3 write after abort", mem[8'h09], 8'h81);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_write;
        t_combined_read;
        t_reread;
        t_mismatch;
        t_extra_byte;
        t_index_only;
        t_read_then_write;
        t_abort;
        check("R9 drive only while SCL low", oe_viol, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule